// File: doc/BRIEF.md
# XTS Sector Tweak Sequencer

This block produces the chain of 128-bit tweaks for one storage sector and wraps an external block cipher in the XOR-encrypt-XOR pattern. The caller loads the first tweak with a one-cycle start strobe. That first tweak is the sector's logical address after encryption under a separate tweak key, and it is computed outside this block. From then on, each plaintext block that is accepted is XORed with the current tweak and passed to the cipher request port. The tweak then moves one step: it is doubled in GF(2^128).

Ciphertext blocks come back on the cipher response port in request order. Each one is XORed again with the tweak that belongs to it. A small tweak FIFO, sized to the number of blocks the cipher can hold at once, keeps that pairing correct when the cipher is pipelined. The response then leaves on the ciphertext stream.

A sector is 4096 bytes, so it holds 256 blocks. After the 256th block has been accepted, further plaintext is refused until the next start. After the 256th ciphertext has been delivered, a done flag rises. The doubling step always XORs the low byte with a reduction constant, either 0x87 or 0x00. The logic therefore does the same work whatever the tweak's top bit is.

Top module: `xts_tweak_seq`

## Requirements
- R1: After reset, and until the first start strobe, `pt_ready_o`, `cq_valid_o`, `ct_valid_o` and `done_o` are all 0, even while `pt_valid_i` is 1.
- R2: A start strobe loads `tweak0_i` as the current tweak. The first block accepted after it is sent out as plaintext XOR `tweak0_i`.
- R3: Each accepted block advances the tweak T to `{T[126:0],1'b0} ^ (T[127] ? 128'h87 : 128'h0)`. This is a one-bit left rotation, with bits 1, 2 and 7 inverted when bit 127 was 1.
- R4: While a block can be taken, `cq_valid_o` follows `pt_valid_i`, `pt_ready_o` follows `cq_ready_i`, and `cq_data_o` equals `pt_data_i` XOR the current tweak.
- R5: The tweak changes only when a plaintext block is accepted (`pt_valid_i && pt_ready_o`). A cycle with backpressure or no data leaves it unchanged.
- R6: `ct_data_o` equals `cr_data_i` XOR the tweak that was used for the same block. Blocks keep request order with up to `FIFO_DEPTH` blocks in the cipher at once.
- R7: Once 256 blocks of a sector have been accepted, `pt_ready_o` and `cq_valid_o` stay 0 until the next start strobe.
- R8: `done_o` rises in the cycle after the 256th ciphertext handshake of a sector and stays at 1 until the next start strobe.
- R9: A start strobe clears both block counts and `done_o`, so a new sector of 256 blocks can follow.
- R10: With `FIFO_DEPTH` blocks accepted but not yet delivered, `pt_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle strobe: load the initial tweak and begin a sector |
| tweak0_i | input | 128 | Initial tweak (encrypted sector address) |
| pt_valid_i | input | 1 | Plaintext block valid |
| pt_data_i | input | 128 | Plaintext block |
| pt_ready_o | output | 1 | Plaintext block accepted when high with valid |
| cq_valid_o | output | 1 | Cipher request valid |
| cq_data_o | output | 128 | Whitened block to the cipher |
| cq_ready_i | input | 1 | Cipher can take a request |
| cr_valid_i | input | 1 | Cipher response valid |
| cr_data_i | input | 128 | Cipher result |
| cr_ready_o | output | 1 | Response taken when high with valid |
| ct_valid_o | output | 1 | Ciphertext block valid |
| ct_data_o | output | 128 | Ciphertext block after output whitening |
| ct_ready_i | input | 1 | Downstream takes the ciphertext |
| done_o | output | 1 | All 256 ciphertext blocks of the sector delivered |

## Verification
The properties assume three things about the cipher and the caller. The cipher returns exactly one response per request, in request order. It never presents a response with nothing outstanding. The caller pulses start only when no block is inside the cipher. The bench's cipher stand-in keeps these assumptions by construction: it is a queue that XORs each request with a fixed key and replies from its head. The bench also pulses start only after the previous sector's last ciphertext has left. Within those limits it varies ready and valid patterns pseudo-randomly. It also holds responses back long enough to fill the tweak FIFO.

// File: rtl/xts_pkg.sv
`timescale 1ns/1ps
// Shared constants for the XTS tweak sequencer.
// Assumes 128-bit cipher blocks split into 8-bit lanes.
package xts_pkg;
    localparam int BLK_W   = 128;
    localparam int LANE_W  = 8;
    localparam int NLANES  = BLK_W / LANE_W;
    localparam logic [LANE_W-1:0] FOLD_POLY = 8'h87;
    typedef logic [BLK_W-1:0] blk_t;
endpackage

// File: rtl/xts_gf_double.sv
`timescale 1ns/1ps
// Multiplies a tweak by alpha (x) in GF(2^128), lane by lane from the low byte up.
// Each lane's top bit carries into bit 0 of the next lane. The final carry picks the
// fold constant, and the low lane is XORed unconditionally (0x87 or 0x00), so the
// work done does not depend on the tweak's top bit. Purely combinational.
module xts_gf_double
    import xts_pkg::*;
#(
    parameter int NL = NLANES
) (
    input  logic [NL*LANE_W-1:0] t_i,
    output logic [NL*LANE_W-1:0] t_o
);
    logic [NL:0] carry;
    logic [LANE_W-1:0] fold;

    assign carry[0] = 1'b0;
    // fold mask is the polynomial gated by the carry out of the top lane
    assign fold = FOLD_POLY & {LANE_W{carry[NL]}};

    generate
        for (genvar b = 0; b < NL; b++) begin : g_lane
            assign carry[b+1] = t_i[b*LANE_W + LANE_W-1];
            if (b == 0) begin : g_low
                // low lane: shift in zero, always XOR with the fold mask
                assign t_o[LANE_W-1:0] = {t_i[LANE_W-2:0], carry[0]} ^ fold;
            end else begin : g_hi
                // upper lanes: shift in the carry from the lane below
                assign t_o[b*LANE_W +: LANE_W] = {t_i[b*LANE_W +: LANE_W-1], carry[b]};
            end
        end
    endgenerate
endmodule

// File: rtl/xts_tweak_fifo.sv
`timescale 1ns/1ps
// Holds the tweaks of blocks that are inside the cipher, in issue order.
// Assumes push is never asserted when full, and pop is never asserted when empty.
// Synchronous clear empties it.
module xts_tweak_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign dout_o  = mem[rd_q];

    // store the pushed tweak
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_q] <= din_i;
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            case ({push_i, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/xts_block_cnt.sv
`timescale 1ns/1ps
// Counts handshakes from 0 up to LIMIT and saturates there.
// at_limit_o is high once LIMIT events have been counted.
// A synchronous clear restarts the count.
module xts_block_cnt #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_limit_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    assign at_limit_o = (cnt_q == CNT_W'(LIMIT));

    // count events, holding at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)             cnt_q <= '0;
        else if (inc_i && !at_limit_o)   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/xts_tweak_seq.sv
`timescale 1ns/1ps
// XTS sector tweak sequencer: loads the initial tweak on start_i and whitens each
// plaintext block with the current tweak before it goes to the cipher.
// It doubles the tweak per accepted block, and whitens each cipher response again
// with its own tweak, which is kept in a FIFO. Assumes the cipher answers in order,
// one response per request. Assumes start_i is pulsed only when no block is in flight.
module xts_tweak_seq
    import xts_pkg::*;
#(
    parameter int SECTOR_BYTES = 4096,
    parameter int FIFO_DEPTH   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] tweak0_i,
    input  logic             pt_valid_i,
    input  logic [BLK_W-1:0] pt_data_i,
    output logic             pt_ready_o,
    output logic             cq_valid_o,
    output logic [BLK_W-1:0] cq_data_o,
    input  logic             cq_ready_i,
    input  logic             cr_valid_i,
    input  logic [BLK_W-1:0] cr_data_i,
    output logic             cr_ready_o,
    output logic             ct_valid_o,
    output logic [BLK_W-1:0] ct_data_o,
    input  logic             ct_ready_i,
    output logic             done_o
);
    localparam int SECTOR_BLOCKS = SECTOR_BYTES / (BLK_W / 8);

    blk_t tweak_q, tweak_nxt, tweak_head;
    logic active_q;
    logic in_full, fifo_full, fifo_empty;
    logic can_take, in_fire, out_fire;

    // block can be taken: sector open, not restarting, room left in sector and FIFO
    assign can_take   = active_q && !start_i && !in_full && !fifo_full;
    assign pt_ready_o = can_take && cq_ready_i;
    assign cq_valid_o = can_take && pt_valid_i;
    assign cq_data_o  = pt_data_i ^ tweak_q;
    assign in_fire    = pt_valid_i && pt_ready_o;

    // response side pairs the cipher result with the oldest stored tweak
    assign ct_valid_o = cr_valid_i && !fifo_empty;
    assign cr_ready_o = ct_ready_i && !fifo_empty;
    assign ct_data_o  = cr_data_i ^ tweak_head;
    assign out_fire   = ct_valid_o && ct_ready_i;

    xts_gf_double #(.NL(NLANES)) u_dbl (
        .t_i (tweak_q),
        .t_o (tweak_nxt)
    );

    // sector open flag: set by the first start strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       active_q <= 1'b0;
        else if (start_i) active_q <= 1'b1;
    end

    // current tweak: load on start, double on each accepted block
    always_ff @(posedge clk) begin
        if (!rst_n)       tweak_q <= '0;
        else if (start_i) tweak_q <= tweak0_i;
        else if (in_fire) tweak_q <= tweak_nxt;
    end

    xts_tweak_fifo #(.W(BLK_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_i),
        .push_i  (in_fire),
        .din_i   (tweak_q),
        .pop_i   (out_fire),
        .dout_o  (tweak_head),
        .full_o  (fifo_full),
        .empty_o (fifo_empty)
    );

    xts_block_cnt #(.LIMIT(SECTOR_BLOCKS)) u_in_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (start_i),
        .inc_i      (in_fire),
        .at_limit_o (in_full)
    );

    xts_block_cnt #(.LIMIT(SECTOR_BLOCKS)) u_out_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (start_i),
        .inc_i      (out_fire),
        .at_limit_o (done_o)
    );
endmodule

// File: rtl/xts_tweak_seq_chk.sv
`timescale 1ns/1ps
// Property checker for xts_tweak_seq, attached with bind below.
// Assumes in-order cipher responses and start only when nothing is in flight.
module xts_tweak_seq_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [127:0] tweak0_i,
    input logic         pt_valid_i,
    input logic         pt_ready_o,
    input logic         cq_valid_o,
    input logic         ct_valid_o,
    input logic         ct_ready_i,
    input logic         done_o,
    input logic [127:0] tweak_q,
    input logic         in_full,
    input logic         fifo_full
);
    logic seen_start;

    function automatic logic [127:0] ref_step(input logic [127:0] t);
        return {t[126:0], 1'b0} ^ {120'd0, (t[127] ? 8'h87 : 8'h00)};
    endfunction

    // remembers whether a sector was ever opened
    always_ff @(posedge clk) begin
        if (!rst_n)       seen_start <= 1'b0;
        else if (start_i) seen_start <= 1'b1;
    end

    // R1
    idle_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_start |-> (!pt_ready_o && !cq_valid_o && !ct_valid_o && !done_o));

    // R2
    tweak_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tweak_q == $past(tweak0_i)));

    // R3
    tweak_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_valid_i && pt_ready_o && !start_i) |=> (tweak_q == ref_step($past(tweak_q))));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !(pt_valid_i && pt_ready_o)) |=> $stable(tweak_q));

    // R7
    sector_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_full |-> (!pt_ready_o && !cq_valid_o));

    // R8
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(ct_valid_o && ct_ready_i));

    // R10
    fifo_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !pt_ready_o);
endmodule

bind xts_tweak_seq xts_tweak_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tweak0_i   (tweak0_i),
    .pt_valid_i (pt_valid_i),
    .pt_ready_o (pt_ready_o),
    .cq_valid_o (cq_valid_o),
    .ct_valid_o (ct_valid_o),
    .ct_ready_i (ct_ready_i),
    .done_o     (done_o),
    .tweak_q    (tweak_q),
    .in_full    (in_full),
    .fifo_full  (fifo_full)
);

// File: tb/xts_tweak_seq_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected ciphertext into a queue. A monitor loop
// checks requests against a reference tweak model and pops expected items as ciphertext leaves.
// A queue-based cipher stand-in XORs each request with a fixed key.
module xts_tweak_seq_tb;
    localparam int LIMIT = 256;
    localparam int DEPTH = 4;
    localparam logic [127:0] KEY = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] tweak0_i = '0;
    logic         pt_valid_i = 1'b0;
    logic [127:0] pt_data_i = '0;
    logic         pt_ready_o;
    logic         cq_valid_o;
    logic [127:0] cq_data_o;
    logic         cq_ready_i = 1'b0;
    logic         cr_valid_i = 1'b0;
    logic [127:0] cr_data_i = '0;
    logic         cr_ready_o;
    logic         ct_valid_o;
    logic [127:0] ct_data_o;
    logic         ct_ready_i = 1'b0;
    logic         done_o;

    int           n_chk = 0;
    int           n_fail = 0;
    int           acc_cnt = 0;
    int           out_cnt = 0;
    logic [127:0] model_tweak = '0;
    logic [127:0] exp_q[$];
    logic [127:0] stub_q[$];
    logic [15:0]  lfsr = 16'hACE1;
    bit           bp_on = 1'b0;
    bit           hold_resp = 1'b0;

    always #2.5 clk = ~clk;

    xts_tweak_seq #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tweak0_i(tweak0_i),
        .pt_valid_i(pt_valid_i), .pt_data_i(pt_data_i), .pt_ready_o(pt_ready_o),
        .cq_valid_o(cq_valid_o), .cq_data_o(cq_data_o), .cq_ready_i(cq_ready_i),
        .cr_valid_i(cr_valid_i), .cr_data_i(cr_data_i), .cr_ready_o(cr_ready_o),
        .ct_valid_o(ct_valid_o), .ct_data_o(ct_data_o), .ct_ready_i(ct_ready_i),
        .done_o(done_o)
    );

    function automatic logic [127:0] gf_ref(input logic [127:0] t);
        return {t[126:0], 1'b0} ^ (t[127] ? 128'h87 : 128'h0);
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor and cipher stand-in: drive stub at negedge, sample 2 ns later
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cq_ready_i = bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
            cr_valid_i = (stub_q.size() > 0) && !hold_resp && (bp_on ? (lfsr[5] | lfsr[1]) : 1'b1);
            cr_data_i  = (stub_q.size() > 0) ? stub_q[0] : '0;
            ct_ready_i = bp_on ? (lfsr[7] | lfsr[2]) : 1'b1;
            #2;
            if (rst_n) begin
                // R8 R9: done reflects all 256 delivered before this cycle
                check(done_o == (out_cnt == LIMIT), "R8 R9 done", {127'd0, done_o}, {127'd0, out_cnt == LIMIT});
                // R10: FIFO full of in-flight blocks refuses input
                if ((acc_cnt - out_cnt) == DEPTH && pt_valid_i && cq_ready_i)
                    check(!pt_ready_o, "R10 full", {127'd0, pt_ready_o}, '0);
                if (pt_valid_i && pt_ready_o) begin
                    // R2 R3 R4 R5: request uses the model tweak
                    check(cq_valid_o && cq_data_o == (pt_data_i ^ model_tweak), "R2 R3 R4 R5 request",
                          cq_data_o, pt_data_i ^ model_tweak);
                    exp_q.push_back(pt_data_i ^ KEY);
                    stub_q.push_back(cq_data_o ^ KEY);
                    model_tweak = gf_ref(model_tweak);
                    acc_cnt++;
                end
                if (ct_valid_o && ct_ready_i) begin
                    logic [127:0] e;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
                    // R6: output whitening uses the matching tweak
                    check(ct_data_o == e && cr_ready_o, "R6 ciphertext", ct_data_o, e);
                    if (stub_q.size() > 0) void'(stub_q.pop_front());
                    out_cnt++;
                end
                if (start_i) begin
                    model_tweak = tweak0_i;
                    acc_cnt = 0;
                    out_cnt = 0;
                end
            end
        end
    end

    task automatic send(input logic [127:0] d);
        int stalls;
        stalls = 0;
        @(negedge clk);
        pt_valid_i = 1'b1;
        pt_data_i  = d;
        #2;
        while (!pt_ready_o) begin
            @(negedge clk);
            stalls++;
            if (stalls > 6) hold_resp = 1'b0;
            #2;
        end
    endtask

    task automatic run_sector(input logic [127:0] t0, input bit bp, input bit hold, input int seed);
        @(negedge clk);
        start_i = 1'b1; tweak0_i = t0; pt_valid_i = 1'b0; bp_on = bp; hold_resp = hold;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < LIMIT; i++) begin
            send({4{32'(i * 32'h9E3779B1) ^ 32'(seed)}} ^ {96'd0, 32'(i)});
            if (bp && lfsr[9]) begin
                @(negedge clk);
                pt_valid_i = 1'b0;
            end
        end
        @(negedge clk);
        pt_valid_i = 1'b0;
        hold_resp = 1'b0;
        while (out_cnt < LIMIT) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_refused(input string req);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            pt_valid_i = 1'b1;
            pt_data_i  = 128'hDEAD;
            #2;
            check(!pt_ready_o && !cq_valid_o, req, {126'd0, pt_ready_o, cq_valid_o}, '0);
        end
        @(negedge clk);
        pt_valid_i = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    // main sequence
    initial begin
        pt_valid_i = 1'b1;
        repeat (4) @(negedge clk);
        #2;
        // R1: outputs idle during reset
        check(!pt_ready_o && !ct_valid_o && !done_o, "R1 in reset", {125'd0, pt_ready_o, ct_valid_o, done_o}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #2;
            // R1: no acceptance before first start
            check(!pt_ready_o && !cq_valid_o && !ct_valid_o && !done_o, "R1 before start",
                  {124'd0, pt_ready_o, cq_valid_o, ct_valid_o, done_o}, '0);
            @(negedge clk);
        end
        pt_valid_i = 1'b0;

        // sector with top tweak bit set, responses held to fill the FIFO (R10)
        run_sector(128'h80000000_00000000_00000000_000000C3, 1'b0, 1'b1, 32'h1111);
        // R7: sector full, input refused
        check_refused("R7 after sector");
        // sector with top bit clear under random backpressure (R5, R9)
        run_sector(128'h40000001_23456789_ABCDEF01_02030405, 1'b1, 1'b0, 32'h2222);
        check_refused("R7 second sector");
        // all-ones tweak, backpressure and held responses
        run_sector('1, 1'b1, 1'b1, 32'h3333);
        check(exp_q.size() == 0, "R6 drained", 128'(exp_q.size()), '0);

        summary();
        $finish;
    end
endmodule